// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block sits between a processor bus and the priority core of an eight-input interrupt controller. The processor sees two consecutive byte addresses. Writes to them carry initialization words and operation words. The block tells these apart by the address bit and by marker bits inside each byte. It keeps the programmed routine address and the interval choice, and it holds the mask register. It also holds the special-mask flag and the status-read selection.

The block turns end-of-interrupt, rotation and bottom-priority commands into one-cycle strobes that carry a level code for the priority core. Reads at the low address return the request register or the in-service register supplied by the core. A poll byte can be returned in place of that read. Reads at the high address return the mask.

During an acknowledge sequence the block drives three bytes on the read data. The first is a call opcode. The second and third are the low and high bytes of the service-routine address, built from the programmed bits and the winning level. Priority arbitration is not part of this block. The winning level arrives as an input.

Top module: `irq_cmd_port`

## Requirements
- R1: After reset, rdata is 0x00, mask_out is 0x00, init_done is 0, special_mask is 0, and every command strobe and svc_stb is low.
- R2: A low-address write with data bit 4 set is an initialization word. It stores data bits 7..5 as routine-address bits A7..A5 and data bit 2 as the interval flag (1 = 4 bytes, 0 = 8 bytes). It clears the mask, the special mask flag and any pending poll, and selects the request register for reads. It raises prio_reset_stb for one cycle and drops init_done. The next high-address write loads A15..A8 and sets init_done. That write does not touch the mask.
- R3: Until init_done is set, operation words at the low address give no strobe and change no state. A high-address write made before any initialization word does not change the mask.
- R4: A low-address write with bits 4..3 = 00, after init, is an action word. Bits 7..5 select the action: 001 gives eoi_ns_stb; 101 gives eoi_ns_stb with rot_stb; 011 gives eoi_sp_stb; 111 gives eoi_sp_stb with rot_stb; 110 gives bottom_stb. For the last three, cmd_level = bits 2..0. Other codes give no strobe. Each strobe is high for exactly the one cycle after the write.
- R5: After init, a high-address write loads mask_out (1 = masked), and a high-address read returns the mask.
- R6: A low-address write with bits 4..3 = 01, after init, is a status word. Bits 1..0 = 10 select the request register for low-address reads. Bits 1..0 = 11 select the in-service register. Other values keep the current choice, and the choice persists across reads.
- R7: In a status word, bits 6..5 = 11 set special_mask and 10 clear it. Other values leave it unchanged.
- R8: A status word with bit 2 set arms a poll. The next low-address read returns bit 7 = win_valid and bits 2..0 = win_level, with the other bits 0. When win_valid is 1, that read also pulses svc_stb with svc_level = win_level. Later reads return the selected register again.
- R9: Acknowledge pulses cycle through three phases. The first returns 0xCD and, when win_valid is 1, pulses svc_stb with the level latched at that pulse. The second returns the routine-address low byte. The third returns A15..A8.
- R10: The low byte is {A7,A6,A5,L2,L1,L0,0,0} for the 4-byte interval and {A7,A6,L2,L1,L0,0,0,0} for the 8-byte interval, where L is the level latched at the first acknowledge pulse.
- R11: Read data is registered and appears in the cycle after the read or acknowledge. An acknowledge in the same cycle as a read takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_hi | input | 1 | Port address bit (0 = command/status, 1 = mask/second word) |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| ack | input | 1 | Acknowledge pulse, one cycle each |
| win_valid | input | 1 | Priority core has a winning level |
| win_level | input | 3 | Winning level code |
| req_vec | input | 8 | Request register from the core |
| isr_vec | input | 8 | In-service register from the core |
| rdata | output | 8 | Registered read / acknowledge data |
| mask_out | output | 8 | Mask register |
| init_done | output | 1 | Initialization sequence complete |
| special_mask | output | 1 | Special mask mode flag |
| prio_reset_stb | output | 1 | Pulse: reset rotation state in the core |
| eoi_ns_stb | output | 1 | Pulse: non-specific end of interrupt |
| eoi_sp_stb | output | 1 | Pulse: specific end of interrupt at cmd_level |
| rot_stb | output | 1 | Qualifies an EOI strobe: rotate priority |
| bottom_stb | output | 1 | Pulse: make cmd_level the bottom priority |
| cmd_level | output | 3 | Level code for specific commands |
| svc_stb | output | 1 | Pulse: level accepted for service |
| svc_level | output | 3 | Level accepted for service |

## Verification
The bench re-initializes with the other interval. A design that kept the old interval flag, or did not clear the mask, would return a wrong low byte or a stale mask. It writes the mask before any initialization word and writes action words before the second initialization word. A decoder that skipped the init gate would move the mask or fire strobes. A poll read is followed by a plain read, so a poll that never disarmed would keep returning the poll byte. A poll with no pending level must return zero without a service pulse. An acknowledge that collides with a read must still return the call opcode.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
  localparam int DATA_W = 8;
  localparam int LVL_W  = 3;

  typedef enum logic [1:0] {ST_RAW, ST_WAIT_HI, ST_READY} init_st_t;
  typedef enum logic {SRC_REQ, SRC_SVC} stat_src_t;

  // Routine-address low byte from programmed bits, level and interval flag.
  function automatic logic [DATA_W-1:0] vec_low_byte(
      input logic [2:0] a_mid, input logic [LVL_W-1:0] lvl, input logic iv4);
    if (iv4) return {a_mid, lvl, 2'b00};
    else     return {a_mid[2:1], lvl, 3'b000};
  endfunction

  // Poll response byte: pending flag on top, level code at the bottom.
  function automatic logic [DATA_W-1:0] poll_byte(
      input logic valid, input logic [LVL_W-1:0] lvl);
    return {valid, {(DATA_W-LVL_W-1){1'b0}}, (valid ? lvl : {LVL_W{1'b0}})};
  endfunction

  function automatic logic is_action_word(input logic [DATA_W-1:0] d);
    return d[4:3] == 2'b00;
  endfunction

  function automatic logic is_status_word(input logic [DATA_W-1:0] d);
    return d[4:3] == 2'b01;
  endfunction
endpackage

// File: rtl/icp_init_seq.sv
module icp_init_seq
  import irq_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              icw1_hit,
  input  logic              wr_hi,
  input  logic [2:0]        icw1_addr,
  input  logic              icw1_iv4,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] a_hi,
  output logic [2:0]        a_mid,
  output logic              iv4,
  output logic [DATA_W-1:0] mask,
  output logic              ready,
  output logic              prio_reset_stb
);
  init_st_t st;
  logic     hi_load_addr;
  logic     hi_load_mask;

  assign hi_load_addr = wr_hi && (st == ST_WAIT_HI) && !icw1_hit;
  assign hi_load_mask = wr_hi && (st == ST_READY) && !icw1_hit;
  assign ready        = (st == ST_READY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= ST_RAW;
      a_hi           <= '0;
      a_mid          <= '0;
      iv4            <= 1'b0;
      mask           <= '0;
      prio_reset_stb <= 1'b0;
    end else begin
      prio_reset_stb <= icw1_hit;
      if (icw1_hit) begin
        st    <= ST_WAIT_HI;
        a_mid <= icw1_addr;
        iv4   <= icw1_iv4;
        mask  <= '0;
      end else if (hi_load_addr) begin
        a_hi <= wdata;
        st   <= ST_READY;
      end else if (hi_load_mask) begin
        mask <= wdata;
      end
    end
  end

  // R2: an initialization word clears the mask and drops readiness
  assert_icw1_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_hit |=> (mask == '0) && !ready && prio_reset_stb);

  // R3, R5: the mask moves only on a high write or an initialization word
  assert_mask_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask) |-> ($past(wr_hi) || $past(icw1_hit)));

  // R3: a high write in the raw state leaves the mask alone
  assert_raw_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !icw1_hit && st == ST_RAW) |=> $stable(mask));
endmodule

// File: rtl/icp_op_decode.sv
module icp_op_decode
  import irq_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic              wr_lo,
  input  logic              icw1_hit,
  input  logic              poll_take,
  input  logic [DATA_W-1:0] wdata,
  output logic              eoi_ns_stb,
  output logic              eoi_sp_stb,
  output logic              rot_stb,
  output logic              bottom_stb,
  output logic [LVL_W-1:0]  cmd_level,
  output logic              smm,
  output stat_src_t         src_sel,
  output logic              poll_armed
);
  logic       act_hit;
  logic       stat_hit;
  logic [2:0] code;

  assign act_hit  = wr_lo && ready && !icw1_hit && is_action_word(wdata);
  assign stat_hit = wr_lo && ready && !icw1_hit && is_status_word(wdata);
  assign code     = wdata[7:5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoi_ns_stb <= 1'b0;
      eoi_sp_stb <= 1'b0;
      rot_stb    <= 1'b0;
      bottom_stb <= 1'b0;
      cmd_level  <= '0;
      smm        <= 1'b0;
      src_sel    <= SRC_REQ;
      poll_armed <= 1'b0;
    end else begin
      eoi_ns_stb <= 1'b0;
      eoi_sp_stb <= 1'b0;
      rot_stb    <= 1'b0;
      bottom_stb <= 1'b0;
      if (icw1_hit) begin
        smm        <= 1'b0;
        src_sel    <= SRC_REQ;
        poll_armed <= 1'b0;
      end else begin
        if (poll_take) poll_armed <= 1'b0;
        if (act_hit) begin
          cmd_level <= wdata[LVL_W-1:0];
          case (code)
            3'b001: eoi_ns_stb <= 1'b1;
            3'b101: begin eoi_ns_stb <= 1'b1; rot_stb <= 1'b1; end
            3'b011: eoi_sp_stb <= 1'b1;
            3'b111: begin eoi_sp_stb <= 1'b1; rot_stb <= 1'b1; end
            3'b110: bottom_stb <= 1'b1;
            default: ;
          endcase
        end
        if (stat_hit) begin
          if (wdata[2]) poll_armed <= 1'b1;
          if (wdata[1]) src_sel <= wdata[0] ? SRC_SVC : SRC_REQ;
          if (wdata[6]) smm <= wdata[5];
        end
      end
    end
  end

  // R3: no command strobe follows a low write made before init completes
  assert_gate_before_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !ready) |=> !(eoi_ns_stb || eoi_sp_stb || bottom_stb));

  // R4: a rotate qualifier never appears without an end-of-interrupt strobe
  assert_rot_needs_eoi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rot_stb |-> (eoi_ns_stb || eoi_sp_stb));

  // R4: strobes last one cycle unless a new action word arrived
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ns_stb && !act_hit) |=> !eoi_ns_stb);

  // R2, R7: an initialization word clears special mask and poll
  assert_icw1_modes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_hit |=> (!smm && !poll_armed && src_sel == SRC_REQ));

  // R8: a consumed poll disarms unless re-armed in the same cycle
  assert_poll_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !(stat_hit && wdata[2])) |=> !poll_armed);
endmodule

// File: rtl/icp_read_path.sv
module icp_read_path
  import irq_cmd_pkg::*;
#(
  parameter logic [DATA_W-1:0] CALL_OP = 8'hCD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic              ack,
  input  logic              poll_armed,
  input  stat_src_t         src_sel,
  input  logic [DATA_W-1:0] req_vec,
  input  logic [DATA_W-1:0] isr_vec,
  input  logic [DATA_W-1:0] mask,
  input  logic              win_valid,
  input  logic [LVL_W-1:0]  win_level,
  input  logic [DATA_W-1:0] a_hi,
  input  logic [2:0]        a_mid,
  input  logic              iv4,
  output logic [DATA_W-1:0] rdata,
  output logic              svc_stb,
  output logic [LVL_W-1:0]  svc_level,
  output logic              poll_take
);
  localparam int ACK_PHASES = 3;
  localparam int PH_W       = $clog2(ACK_PHASES);

  logic [PH_W-1:0]   ack_ph;
  logic [LVL_W-1:0]  ack_lvl;
  logic              ack_first;
  logic [DATA_W-1:0] stat_byte;

  assign poll_take = rd_lo && poll_armed && !ack;
  assign ack_first = ack && (ack_ph == '0);
  assign stat_byte = (src_sel == SRC_SVC) ? isr_vec : req_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata     <= '0;
      ack_ph    <= '0;
      ack_lvl   <= '0;
      svc_stb   <= 1'b0;
      svc_level <= '0;
    end else begin
      svc_stb <= 1'b0;
      if (ack) begin
        if (ack_ph == PH_W'(ACK_PHASES - 1)) ack_ph <= '0;
        else                                  ack_ph <= ack_ph + 1'b1;
        case (ack_ph)
          PH_W'(0): begin
            rdata     <= CALL_OP;
            ack_lvl   <= win_level;
            svc_stb   <= win_valid;
            svc_level <= win_level;
          end
          PH_W'(1): rdata <= vec_low_byte(a_mid, ack_lvl, iv4);
          default:  rdata <= a_hi;
        endcase
      end else if (poll_take) begin
        rdata     <= poll_byte(win_valid, win_level);
        svc_stb   <= win_valid;
        svc_level <= win_level;
      end else if (rd_lo) begin
        rdata <= stat_byte;
      end else if (rd_hi) begin
        rdata <= mask;
      end
    end
  end

  // R9, R11: the first acknowledge pulse returns the call opcode next cycle
  assert_call_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_first |=> (rdata == CALL_OP));

  // R8: a poll response never sets the unused middle bits
  assert_poll_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_take |=> (rdata[6:LVL_W] == '0));

  // R9: the acknowledge phase never leaves its three-state cycle
  assert_phase_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ph != PH_W'(ACK_PHASES));

  // R11: rdata holds its value when nothing is read
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_lo || rd_hi || ack) |=> $stable(rdata));
endmodule

// File: rtl/irq_cmd_port.sv
module irq_cmd_port
  import irq_cmd_pkg::*;
#(
  parameter logic [7:0] CALL_OP = 8'hCD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_hi,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  input  logic       ack,
  input  logic       win_valid,
  input  logic [2:0] win_level,
  input  logic [7:0] req_vec,
  input  logic [7:0] isr_vec,
  output logic [7:0] rdata,
  output logic [7:0] mask_out,
  output logic       init_done,
  output logic       special_mask,
  output logic       prio_reset_stb,
  output logic       eoi_ns_stb,
  output logic       eoi_sp_stb,
  output logic       rot_stb,
  output logic       bottom_stb,
  output logic [2:0] cmd_level,
  output logic       svc_stb,
  output logic [2:0] svc_level
);
  // Named internal events
  logic       wr_lo, wr_hi, rd_lo, rd_hi;
  logic       icw1_hit;
  logic       ready;
  logic       poll_armed;
  logic       poll_take;
  logic [7:0] a_hi;
  logic [2:0] a_mid;
  logic       iv4;
  stat_src_t  src_sel;

  assign wr_lo    = wr_en && !addr_hi;
  assign wr_hi    = wr_en &&  addr_hi;
  assign rd_lo    = rd_en && !addr_hi;
  assign rd_hi    = rd_en &&  addr_hi;
  assign icw1_hit = wr_lo && wdata[4];

  icp_init_seq u_init (
    .clk           (clk),
    .rst_n         (rst_n),
    .icw1_hit      (icw1_hit),
    .wr_hi         (wr_hi),
    .icw1_addr     (wdata[7:5]),
    .icw1_iv4      (wdata[2]),
    .wdata         (wdata),
    .a_hi          (a_hi),
    .a_mid         (a_mid),
    .iv4           (iv4),
    .mask          (mask_out),
    .ready         (ready),
    .prio_reset_stb(prio_reset_stb)
  );

  icp_op_decode u_op (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .wr_lo     (wr_lo),
    .icw1_hit  (icw1_hit),
    .poll_take (poll_take),
    .wdata     (wdata),
    .eoi_ns_stb(eoi_ns_stb),
    .eoi_sp_stb(eoi_sp_stb),
    .rot_stb   (rot_stb),
    .bottom_stb(bottom_stb),
    .cmd_level (cmd_level),
    .smm       (special_mask),
    .src_sel   (src_sel),
    .poll_armed(poll_armed)
  );

  icp_read_path #(.CALL_OP(CALL_OP)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .ack       (ack),
    .poll_armed(poll_armed),
    .src_sel   (src_sel),
    .req_vec   (req_vec),
    .isr_vec   (isr_vec),
    .mask      (mask_out),
    .win_valid (win_valid),
    .win_level (win_level),
    .a_hi      (a_hi),
    .a_mid     (a_mid),
    .iv4       (iv4),
    .rdata     (rdata),
    .svc_stb   (svc_stb),
    .svc_level (svc_level),
    .poll_take (poll_take)
  );

  assign init_done = ready;

  // R2: the second initialization word completes init and keeps the mask
  assert_icw2_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !init_done && $past(prio_reset_stb)) |=> init_done);

  // R1: after reset release the block reports no activity in the first cycle
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !(eoi_ns_stb || eoi_sp_stb || bottom_stb || svc_stb || init_done));
endmodule

// File: tb/tb_irq_cmd_port.sv
module tb_irq_cmd_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_hi = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       win_valid = 1'b1;
  logic [2:0] win_level = 3'd5;
  logic [7:0] req_vec = 8'h5A, isr_vec = 8'h24;
  logic [7:0] rdata, mask_out;
  logic       init_done, special_mask, prio_reset_stb;
  logic       eoi_ns_stb, eoi_sp_stb, rot_stb, bottom_stb, svc_stb;
  logic [2:0] cmd_level, svc_level;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #4 clk = ~clk;

  irq_cmd_port dut (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .ack(ack), .win_valid(win_valid), .win_level(win_level),
    .req_vec(req_vec), .isr_vec(isr_vec), .rdata(rdata), .mask_out(mask_out),
    .init_done(init_done), .special_mask(special_mask),
    .prio_reset_stb(prio_reset_stb), .eoi_ns_stb(eoi_ns_stb),
    .eoi_sp_stb(eoi_sp_stb), .rot_stb(rot_stb), .bottom_stb(bottom_stb),
    .cmd_level(cmd_level), .svc_stb(svc_stb), .svc_level(svc_level));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_tests = n_tests + 1;
    if (got !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // One bus cycle: drive at a falling edge, release at the next one.
  // Registered outputs for this access are visible when it returns.
  task automatic bus(input logic w, input logic r, input logic k,
                     input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; ack = k; addr_hi = a; wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0; ack = 0; addr_hi = 0; wdata = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  function automatic logic [3:0] strobes();
    return {eoi_ns_stb, eoi_sp_stb, rot_stb, bottom_stb};
  endfunction

  // Vector: {kind[1:0], addr, data[7:0], expected[7:0]}; kind 0 write, 1 read, 2 ack
  localparam int NV = 21;
  localparam logic [18:0] VEC [0:NV-1] = '{
    {2'd0,1'b0,8'h56,8'h00},  // R2 init word, A7..5=010, 4-byte interval
    {2'd0,1'b1,8'h12,8'h00},  // R2 second word, A15..8=0x12
    {2'd1,1'b0,8'h00,8'h5A},  // R2 R6 request register selected after init
    {2'd0,1'b1,8'hF0,8'h00},  // R5 load mask
    {2'd1,1'b1,8'h00,8'hF0},  // R5 read mask
    {2'd0,1'b0,8'h0B,8'h00},  // R6 select in-service
    {2'd1,1'b0,8'h00,8'h24},  // R6
    {2'd1,1'b0,8'h00,8'h24},  // R6 selection persists
    {2'd2,1'b0,8'h00,8'hCD},  // R9 call opcode
    {2'd2,1'b0,8'h00,8'h54},  // R10 4-byte: 010_101_00
    {2'd2,1'b0,8'h00,8'h12},  // R9 high byte
    {2'd0,1'b0,8'h0C,8'h00},  // R8 arm poll
    {2'd1,1'b0,8'h00,8'h85},  // R8 poll byte, level 5 pending
    {2'd1,1'b0,8'h00,8'h24},  // R8 poll disarmed, in-service again
    {2'd0,1'b0,8'hD2,8'h00},  // R2 re-init A7..5=110, 8-byte interval
    {2'd0,1'b1,8'h40,8'h00},  // R2 A15..8=0x40
    {2'd1,1'b1,8'h00,8'h00},  // R2 mask cleared by init
    {2'd1,1'b0,8'h00,8'h5A},  // R2 request register reselected
    {2'd2,1'b0,8'h00,8'hCD},  // R9
    {2'd2,1'b0,8'h00,8'hE8},  // R10 8-byte: 11_101_000
    {2'd2,1'b0,8'h00,8'h40}   // R9
  };

  initial begin
    // R1 reset state
    do_reset();
    check("R1 rdata", rdata, 8'h00);
    check("R1 mask", mask_out, 8'h00);
    check("R1 flags", {init_done, special_mask, svc_stb}, 3'b000);
    check("R1 strobes", strobes(), 4'b0000);

    // R3 nothing before init
    bus(1, 0, 0, 1, 8'h33);
    bus(0, 1, 0, 1, 8'h00);
    check("R3 mask unchanged before init", rdata, 8'h00);
    bus(1, 0, 0, 0, 8'h20);
    check("R3 EOI ignored before init", strobes(), 4'b0000);
    bus(1, 0, 0, 0, 8'h68);
    check("R3 special mask ignored before init", special_mask, 1'b0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      k = VEC[i][18:17];
      bus(k == 2'd0, k == 2'd1, k == 2'd2, VEC[i][16], VEC[i][15:8]);
      if (i == 0) check("R2 prio reset pulse", prio_reset_stb, 1'b1);
      if (i == 0) check("R2 not done after first word", init_done, 1'b0);
      if (i == 1) check("R2 done after second word", init_done, 1'b1);
      if (i == 8) check("R9 svc pulse level", {svc_stb, svc_level}, {1'b1, 3'd5});
      if (i == 12) check("R8 poll svc pulse", {svc_stb, svc_level}, {1'b1, 3'd5});
      if (k != 2'd0) check($sformatf("R11 vector %0d rdata", i), rdata, VEC[i][7:0]);
    end

    // R4 action words (init complete from the table)
    bus(1, 0, 0, 0, 8'h20);
    check("R4 non-specific EOI", strobes(), 4'b1000);
    @(negedge clk);
    check("R4 strobe lasts one cycle", strobes(), 4'b0000);
    bus(1, 0, 0, 0, 8'hA0);
    check("R4 rotate on EOI", strobes(), 4'b1010);
    bus(1, 0, 0, 0, 8'h63);
    check("R4 specific EOI", {strobes(), cmd_level}, {4'b0100, 3'd3});
    bus(1, 0, 0, 0, 8'hE6);
    check("R4 rotate on specific EOI", {strobes(), cmd_level}, {4'b0110, 3'd6});
    bus(1, 0, 0, 0, 8'hC5);
    check("R4 set bottom", {strobes(), cmd_level}, {4'b0001, 3'd5});
    bus(1, 0, 0, 0, 8'h40);
    check("R4 unused code no strobe", strobes(), 4'b0000);

    // R7 special mask
    bus(1, 0, 0, 0, 8'h68);
    check("R7 set special mask", special_mask, 1'b1);
    bus(1, 0, 0, 0, 8'h08);
    check("R7 no-change code keeps it", special_mask, 1'b1);
    bus(1, 0, 0, 0, 8'h48);
    check("R7 clear special mask", special_mask, 1'b0);

    // R8 poll with nothing pending
    win_valid = 0;
    bus(1, 0, 0, 0, 8'h0C);
    bus(0, 1, 0, 0, 8'h00);
    check("R8 empty poll byte", rdata, 8'h00);
    check("R8 empty poll no svc", svc_stb, 1'b0);
    win_valid = 1;

    // R11 ack and read together: ack wins
    @(negedge clk);
    rd_en = 1; ack = 1;
    @(negedge clk);
    rd_en = 0; ack = 0;
    check("R11 ack precedence", rdata, 8'hCD);

    // R5 mask write after init, R3 write-before-init done above
    bus(1, 0, 0, 1, 8'h81);
    check("R5 mask port", mask_out, 8'h81);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule